// File: doc/BRIEF.md
# Baud-Framed Transmit Control Word Serializer

This block drives the three transmit wires of a serial link to an analog line front end: a continuous oversampling clock (supplied by the surrounding logic), a baud clock that it derives from that clock, and one serial data line. Every baud period spans a fixed number of oversampling cycles. In the first sixteen of those cycles the block shifts out one 16-bit control word, most significant bit first. The word packs a transmit enable, a four-level line symbol, a receive gain code, a loopback request and a power mode.

The user presents the settings on parallel inputs and pulses `loadStb` to stage them. At the edge that opens each baud period the staged settings are turned into the control word. The symbol level is Gray coded, a reserved gain request is clamped, and the unused fields are zeroed. A one-cycle `readyPulse` in slot 0 tells the user that the staging register is free for the next period's settings. If nothing is loaded, the same word is sent again. The data line and the baud clock change on the falling edge of the oversampling clock, so a receiver that samples on the rising edge sees stable values.

Top module: `symTxSerializer`

## Requirements
- R1: A baud period is exactly `SLOTS` (default 48) oversampling cycles long. `baudClk` is high during slots 0 to `SLOTS`/2-1 and low for the rest of the period. It changes only on falling edges of `clk`, and its rise marks slot 0.
- R2: In slots 0 to 15, `serData` carries control-word bits 15 down to 0, one bit per slot. Each new value is driven at the falling edge of `clk` inside its slot and is held across the next rising edge.
- R3: In slots 16 to `SLOTS`-1, `serData` is 0.
- R4: Word bit 15 is `txEnIn`. Bits 14:13 are the Gray code of `levelIn`: level 0 (-3) gives 00, level 1 (-1) gives 01, level 2 (+1) gives 11 and level 3 (+3) gives 10. The symbol bits are packed the same way whether the enable bit is 0 or 1.
- R5: Word bits 12:10 carry `gainIn` when it is 0 to 4. A request of 5, 6 or 7 is sent as 100. `gainErr` equals 1 throughout each baud period whose word was clamped and 0 throughout every other period. It changes only at the start of a period.
- R6: Word bit 9 is `loopIn`, bits 7:6 are `powerIn`, and bits 8 and 5:0 are always 0.
- R7: `readyPulse` is high for exactly one cycle per baud period, the slot 0 cycle.
- R8: A rising edge of `clk` with `loadStb` high stages the settings. Each period's word is built from the settings staged before the edge that opens that period. A load made on that same edge applies to the following period. Without a new load, the word repeats.
- R9: While `rstN` is low, `serData`, `baudClk`, `readyPulse` and `gainErr` are 0 and the staged settings are cleared. The first period after reset therefore sends the word 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Continuous oversampling clock, one cycle per bit slot |
| rstN | input | 1 | Asynchronous active-low reset |
| loadStb | input | 1 | Stages the settings inputs at the rising edge |
| txEnIn | input | 1 | Transmit enable to send |
| levelIn | input | 2 | Symbol level index: 0=-3, 1=-1, 2=+1, 3=+3 |
| gainIn | input | 3 | Requested receive gain code |
| loopIn | input | 1 | Loopback request |
| powerIn | input | 2 | Power mode code |
| readyPulse | output | 1 | One-cycle pulse in slot 0 of each baud period |
| serData | output | 1 | Serial control word line |
| baudClk | output | 1 | Derived baud clock |
| gainErr | output | 1 | High during a baud period whose gain request was clamped |

## Verification
The bench builds the block with the default `SLOTS` of 48. Each captured period therefore covers the full 32-slot idle tail, and the baud clock's falling point sits at slot 24. With this length, the zero fill of the shift register after bit 0, the baud clock's duty split and the single-cycle ready pulse can all be observed at the ports across a whole period. The stimulus covers every symbol level, the last legal gain code and every reserved gain code, loads made on the period boundary, and a reset in mid-period.

// File: rtl/symTxPkg.sv
package symTxPkg;

  localparam int WORD_W = 16;
  localparam int GAIN_W = 3;
  localparam logic [GAIN_W-1:0] GAIN_TOP = 3'd4;

  // strobes from control to datapath
  typedef struct packed {
    logic frameLoad;   // this rising edge opens a new baud period
    logic shiftOn;     // advance the shift register by one slot
    logic baudHigh;    // level the baud clock takes in this slot
  } ctrlStrobeT;

  typedef struct packed {
    logic              txEn;
    logic [1:0]        level;
    logic [GAIN_W-1:0] gain;
    logic              loop;
    logic [1:0]        power;
  } settingsT;

  function automatic logic [1:0] grayOf(input logic [1:0] lvl);
    return {lvl[1], lvl[1] ^ lvl[0]};
  endfunction

endpackage

// File: rtl/symTxCtrl.sv
module symTxCtrl
  import symTxPkg::*;
#(
  parameter int SLOTS = 48,
  localparam int CNT_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rstN,
  output ctrlStrobeT       strobes,
  output logic [CNT_W-1:0] slotIdx,
  output logic             readyPulse
);

  localparam int HALF = SLOTS / 2;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOTS - 1);
  localparam logic [CNT_W-1:0] HALF_IDX = CNT_W'(HALF);

  logic [CNT_W-1:0] slotCnt;
  logic wrap;

  assign wrap = (slotCnt == LAST);

  // reset parks the counter on the last slot so the first edge opens a period
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotCnt <= LAST;
    end else if (wrap) begin
      slotCnt <= '0;
    end else begin
      slotCnt <= slotCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readyPulse <= 1'b0;
    end else begin
      readyPulse <= wrap;
    end
  end

  always_comb begin
    strobes.frameLoad = wrap;
    strobes.shiftOn   = !wrap;
    strobes.baudHigh  = (slotCnt < HALF_IDX);
  end

  assign slotIdx = slotCnt;

endmodule

// File: rtl/symTxPath.sv
module symTxPath
  import symTxPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  ctrlStrobeT strobes,
  input  logic       loadStb,
  input  settingsT   setIn,
  output logic       serData,
  output logic       baudClk,
  output logic       gainErr
);

  settingsT          staged;
  logic [GAIN_W-1:0] gainFix;
  logic              clampHit;
  logic [WORD_W-1:0] wordNext;
  logic [WORD_W-1:0] shReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      staged <= '0;
    end else if (loadStb) begin
      staged <= setIn;
    end
  end

  always_comb begin
    clampHit = (staged.gain > GAIN_TOP);
    gainFix  = clampHit ? GAIN_TOP : staged.gain;
    wordNext = {staged.txEn, grayOf(staged.level), gainFix, staged.loop,
                1'b0, staged.power, 6'b000000};
  end

  // zero fill: after the last word bit leaves, the idle slots read 0
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0;
    end else if (strobes.frameLoad) begin
      shReg <= wordNext;
    end else if (strobes.shiftOn) begin
      shReg <= {shReg[WORD_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gainErr <= 1'b0;
    end else if (strobes.frameLoad) begin
      gainErr <= clampHit;
    end
  end

  // line outputs move half a cycle ahead of the receiver's sampling edge
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      serData <= 1'b0;
      baudClk <= 1'b0;
    end else begin
      serData <= shReg[WORD_W-1];
      baudClk <= strobes.baudHigh;
    end
  end

endmodule

// File: rtl/symTxSerializer.sv
module symTxSerializer
  import symTxPkg::*;
#(
  parameter int SLOTS = 48
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       loadStb,
  input  logic       txEnIn,
  input  logic [1:0] levelIn,
  input  logic [2:0] gainIn,
  input  logic       loopIn,
  input  logic [1:0] powerIn,
  output logic       readyPulse,
  output logic       serData,
  output logic       baudClk,
  output logic       gainErr
);

  localparam int CNT_W = $clog2(SLOTS);

  ctrlStrobeT       strobes;
  settingsT         setIn;
  logic [CNT_W-1:0] slotCnt;

  assign setIn = '{txEn: txEnIn, level: levelIn, gain: gainIn,
                   loop: loopIn, power: powerIn};

  symTxCtrl #(.SLOTS(SLOTS)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .slotIdx   (slotCnt),
    .readyPulse(readyPulse)
  );

  symTxPath i_path (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .loadStb(loadStb),
    .setIn  (setIn),
    .serData(serData),
    .baudClk(baudClk),
    .gainErr(gainErr)
  );

endmodule

// File: rtl/symTxChecker.sv
module symTxChecker
#(
  parameter int SLOTS = 48,
  localparam int CNT_W = $clog2(SLOTS)
) (
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] slotIdx,
  input logic             readyPulse,
  input logic             serData,
  input logic             baudClk,
  input logic             gainErr
);

  localparam logic [CNT_W-1:0] FIRST_IDLE = CNT_W'(16);

  // R7: the ready pulse never lasts two cycles
  assert_ready_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    readyPulse |=> !readyPulse);

  // R1: baud clock rises in the slot flagged by the ready pulse
  assert_ready_at_baud_rise_R1: assert property (@(posedge clk) disable iff (!rstN)
    readyPulse |-> (baudClk && !$past(baudClk)));

  assert_baud_rise_has_ready_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(baudClk) |-> readyPulse);

  // R5: clamp flag only moves at a period start
  assert_gain_err_held_R5: assert property (@(posedge clk) disable iff (!rstN)
    !readyPulse |-> $stable(gainErr));

  // R3: idle slots carry no data
  assert_idle_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (slotIdx >= FIRST_IDLE) |-> !serData);

endmodule

bind symTxSerializer symTxChecker #(.SLOTS(SLOTS)) i_symTxChecker (
  .clk       (clk),
  .rstN      (rstN),
  .slotIdx   (slotCnt),
  .readyPulse(readyPulse),
  .serData   (serData),
  .baudClk   (baudClk),
  .gainErr   (gainErr)
);

// File: tb/test_symTxSerializer.sv
module test_symTxSerializer;

  localparam int CLK_PERIOD = 10;
  localparam int SLOTS = 48;
  localparam int NVEC = 9;

  typedef struct packed {
    logic        en;
    logic [1:0]  lvl;
    logic [2:0]  gain;
    logic        lp;
    logic [1:0]  pwr;
    logic [15:0] word;
    logic        err;
  } vecT;

  // stimulus and expected word / clamp flag
  localparam vecT VECS [NVEC] = '{
    '{1'b1, 2'd0, 3'd0, 1'b0, 2'd2, 16'h8080, 1'b0},
    '{1'b1, 2'd1, 3'd1, 1'b1, 2'd1, 16'hA640, 1'b0},
    '{1'b1, 2'd2, 3'd2, 1'b0, 2'd3, 16'hE8C0, 1'b0},
    '{1'b1, 2'd3, 3'd3, 1'b1, 2'd0, 16'hCE00, 1'b0},
    '{1'b0, 2'd3, 3'd4, 1'b0, 2'd2, 16'h5080, 1'b0},
    '{1'b1, 2'd1, 3'd5, 1'b0, 2'd1, 16'hB040, 1'b1},
    '{1'b0, 2'd0, 3'd7, 1'b1, 2'd3, 16'h12C0, 1'b1},
    '{1'b1, 2'd2, 3'd6, 1'b1, 2'd1, 16'hF240, 1'b1},
    '{1'b0, 2'd0, 3'd0, 1'b0, 2'd0, 16'h0000, 1'b0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b1;
  logic loadStb = 1'b0;
  logic txEnIn = 1'b0;
  logic [1:0] levelIn = '0;
  logic [2:0] gainIn = '0;
  logic loopIn = 1'b0;
  logic [1:0] powerIn = '0;
  logic readyPulse, serData, baudClk, gainErr;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  symTxSerializer #(.SLOTS(SLOTS)) i_symTxSerializer (
    .clk(clk), .rstN(rstN), .loadStb(loadStb), .txEnIn(txEnIn),
    .levelIn(levelIn), .gainIn(gainIn), .loopIn(loopIn), .powerIn(powerIn),
    .readyPulse(readyPulse), .serData(serData), .baudClk(baudClk),
    .gainErr(gainErr)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic applySettings(input vecT v);
    txEnIn = v.en; levelIn = v.lvl; gainIn = v.gain; loopIn = v.lp; powerIn = v.pwr;
  endtask

  // steps to the sample point (just after the falling edge) of slot 0
  task automatic waitSlot0();
    do begin
      @(negedge clk); #1;
    end while (readyPulse !== 1'b1);
  endtask

  // called at the slot 0 sample point; ends at the last slot's sample point
  task automatic captureFrame(input string tag, input logic [15:0] expWord, input logic expErr);
    logic [15:0] w = '0;
    logic prev = 1'b0;
    bit idleBad = 0, baudBad = 0, rdyBad = 0, errBad = 0, edgeBad = 0;
    for (int s = 0; s < SLOTS; s++) begin
      if (s > 0) begin
        @(posedge clk); #1;
        if (serData !== prev) edgeBad = 1;
        @(negedge clk); #1;
      end
      prev = serData;
      if (s < 16) w[15 - s] = serData;
      else if (serData !== 1'b0) idleBad = 1;
      if (baudClk !== (s < SLOTS / 2)) baudBad = 1;
      if (readyPulse !== (s == 0)) rdyBad = 1;
      if (gainErr !== expErr) errBad = 1;
    end
    check({tag, " R2 R4 R5 R6 word"}, {16'h0, w}, {16'h0, expWord});
    check({tag, " R2 data held over rising edge"}, {31'h0, edgeBad}, 32'h0);
    check({tag, " R3 idle slots zero"}, {31'h0, idleBad}, 32'h0);
    check({tag, " R1 baud clock shape"}, {31'h0, baudBad}, 32'h0);
    check({tag, " R7 ready only in slot 0"}, {31'h0, rdyBad}, 32'h0);
    check({tag, " R5 gainErr over period"}, {31'h0, errBad}, 32'h0);
  endtask

  initial begin
    #1 rstN = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check("R9 reset serData", {31'h0, serData}, 32'h0);
    check("R9 reset baudClk", {31'h0, baudClk}, 32'h0);
    check("R9 reset readyPulse", {31'h0, readyPulse}, 32'h0);
    check("R9 reset gainErr", {31'h0, gainErr}, 32'h0);
    rstN = 1'b1;

    waitSlot0();
    captureFrame("R9 first period", 16'h0000, 1'b0);

    // table walk: load in slot 0, check the following period
    for (int i = 0; i < NVEC; i++) begin
      waitSlot0();
      applySettings(VECS[i]);
      loadStb = 1'b1;
      @(posedge clk); #1;
      loadStb = 1'b0;
      waitSlot0();
      captureFrame($sformatf("vec%0d", i), VECS[i].word, VECS[i].err);
    end

    // R8: no load, word repeats
    waitSlot0();
    captureFrame("R8 repeat", VECS[NVEC-1].word, VECS[NVEC-1].err);

    // R8: load on the edge that opens a period lands one period later
    applySettings(VECS[5]);
    loadStb = 1'b1;
    waitSlot0();
    loadStb = 1'b0;
    captureFrame("R8 boundary old", VECS[NVEC-1].word, VECS[NVEC-1].err);
    waitSlot0();
    captureFrame("R8 boundary new", VECS[5].word, VECS[5].err);

    // R9: reset in mid-period clears outputs and staged settings
    repeat (7) @(negedge clk);
    #1 rstN = 1'b0;
    #1;
    check("R9 mid reset serData", {31'h0, serData}, 32'h0);
    check("R9 mid reset baudClk", {31'h0, baudClk}, 32'h0);
    check("R9 mid reset readyPulse", {31'h0, readyPulse}, 32'h0);
    check("R9 mid reset gainErr", {31'h0, gainErr}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    waitSlot0();
    captureFrame("R9 after mid reset", 16'h0000, 1'b0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule